// File: doc/BRIEF.md
# Multi-mode serial baud tick generator

This block produces the timing strobes for a serial port that can run either asynchronously or with a shared clock. An 8-bit divisor sets the reload period of a free-running timer, and the timer's overflow feeds a fixed prescaler. Two mode inputs select the prescale ratio. In asynchronous operation the ratio is 64 when the speed bit is clear and 16 when it is set. In synchronous operation the ratio is always 4, whatever the speed bit says. The block emits a one-cycle bit-rate tick. It also emits a one-cycle strobe on every timer overflow, which asynchronous receivers use as a 16x oversampling clock.

A write to the divisor clears the timer and the prescaler in the same cycle. The new rate therefore starts at once, without waiting for the old period to run out. The raw receive line first passes through a two-flop synchronizer. It is then sampled on three successive overflow strobes around the middle of each bit, and a registered majority of those samples gives the filtered receive level.

Top module: `baud_gen`

## Requirements
- R1: After reset the divisor is 0, `baud_tick` is low and `rx_level` is 1. With both mode bits low, the first tick is high 63 falling-edge samples after the last reset edge.
- R2: `ovs_strobe` pulses once every X+1 clock cycles, where X is the stored divisor (0 to 255).
- R3: With `mode_sync`=0 and `mode_fast`=0, ticks are spaced 64·(X+1) cycles apart.
- R4: With `mode_sync`=0 and `mode_fast`=1, ticks are spaced 16·(X+1) cycles apart.
- R5: With `mode_sync`=1, ticks are spaced 4·(X+1) cycles apart, and `mode_fast` has no effect.
- R6: `baud_tick` lasts one cycle and is only ever high in a cycle where `ovs_strobe` is high.
- R7: A divisor write clears the timer and the prescaler. With ratio P, the first tick is high P·(X+1)−1 cycles after the edge that captured the write, even when the write lands mid-period.
- R8: `rx_raw` passes two synchronizer flops. Let P be the ratio and phases be counted 0..P−1 from the last clear. It is then sampled on the overflow strobes at prescaler phases P/2−2, P/2−1 and P/2. `rx_level` takes the majority of the three samples at the edge of the third sample and holds at all other times.
- R9: A single sample that disagrees with the other two does not change `rx_level`; two agreeing samples decide it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 8 | Divisor value X |
| mode_sync | input | 1 | 1 selects synchronous operation |
| mode_fast | input | 1 | High-speed select (asynchronous only) |
| rx_raw | input | 1 | Unsynchronized receive line |
| baud_tick | output | 1 | One-cycle bit-rate pulse |
| ovs_strobe | output | 1 | One-cycle pulse per timer overflow |
| rx_level | output | 1 | Majority-voted receive level |

## Verification
The embedded assertions check several rules on every cycle. The timer never runs past the divisor. A write leaves both the timer and the prescaler at zero on the next cycle. A tick always coincides with an overflow and never lasts two cycles. The voted level moves only on the edge after a third sample. The exact tick spacings for each mode and divisor, including the speed bit being ignored in synchronous mode, can only be shown by the bench scenarios. The same holds for the restart latency after a mid-period write and for the glitch rejection of the voter.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int DIV_W  = 8;
    localparam int PHASE_W = 6;

    typedef enum logic [1:0] {
        PS_DIV4  = 2'd0,
        PS_DIV16 = 2'd1,
        PS_DIV64 = 2'd2
    } presc_e;

    typedef struct packed {
        logic first;
        logic second;
    } rx_hold_t;

    function automatic presc_e presc_sel(input logic sync_mode, input logic fast);
        if (sync_mode) return PS_DIV4;
        else if (fast) return PS_DIV16;
        else           return PS_DIV64;
    endfunction

    function automatic logic [PHASE_W-1:0] presc_last(input presc_e sel);
        case (sel)
            PS_DIV4:  return PHASE_W'(3);
            PS_DIV16: return PHASE_W'(15);
            default:  return PHASE_W'(63);
        endcase
    endfunction

    function automatic logic [PHASE_W-1:0] presc_mid(input presc_e sel);
        return PHASE_W'((32'(presc_last(sel)) + 1) / 2);
    endfunction

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/baud_timer.sv
module baud_timer
    import baud_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         ovf
);
    logic [W-1:0] div_q;
    logic [W-1:0] cnt;

    assign ovf = (cnt == div_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (wr) begin
            div_q <= wdata;
            cnt   <= '0;
        end else if (ovf) begin
            cnt   <= '0;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= div_q); // R2
    AST_WR_CLEARS_TIMER: assert property (@(posedge clk) disable iff (rst)
        $past(wr) |-> cnt == '0); // R7
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               ovf,
    input  presc_e             sel,
    output logic [PHASE_W-1:0] phase,
    output logic               tick
);
    logic [PHASE_W-1:0] last;

    assign last = presc_last(sel);
    assign tick = ovf && (phase >= last);

    always_ff @(posedge clk) begin
        if (rst || clr)  phase <= '0;
        else if (tick)   phase <= '0;
        else if (ovf)    phase <= phase + 1'b1;
    end

    AST_TICK_WITH_OVF: assert property (@(posedge clk) disable iff (rst)
        tick |-> ovf); // R6
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R6
    AST_CLR_PHASE: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> phase == '0); // R7
endmodule

// File: rtl/rx_voter.sv
module rx_voter
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_raw,
    input  logic samp_a,
    input  logic samp_b,
    input  logic samp_c,
    output logic level
);
    logic [1:0] sync_q;
    rx_hold_t   hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            hold   <= '{first: 1'b1, second: 1'b1};
            level  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], rx_raw};
            if (samp_a) hold.first  <= sync_q[1];
            if (samp_b) hold.second <= sync_q[1];
            if (samp_c) level <= vote3(hold.first, hold.second, sync_q[1]);
        end
    end

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(samp_c) |-> $stable(level)); // R8
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             mode_sync,
    input  logic             mode_fast,
    input  logic             rx_raw,
    output logic             baud_tick,
    output logic             ovs_strobe,
    output logic             rx_level
);
    presc_e             sel;
    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] mid;
    logic               ovf;
    logic               samp_a, samp_b, samp_c;

    assign sel = presc_sel(mode_sync, mode_fast);
    assign mid = presc_mid(sel);

    baud_timer #(.W(DIV_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .wr    (div_wr),
        .wdata (div_wdata),
        .ovf   (ovf)
    );

    baud_prescaler u_presc (
        .clk   (clk),
        .rst   (rst),
        .clr   (div_wr),
        .ovf   (ovf),
        .sel   (sel),
        .phase (phase),
        .tick  (baud_tick)
    );

    assign samp_a = ovf && (phase == mid - PHASE_W'(2));
    assign samp_b = ovf && (phase == mid - PHASE_W'(1));
    assign samp_c = ovf && (phase == mid);

    rx_voter u_voter (
        .clk    (clk),
        .rst    (rst),
        .rx_raw (rx_raw),
        .samp_a (samp_a),
        .samp_b (samp_b),
        .samp_c (samp_c),
        .level  (rx_level)
    );

    assign ovs_strobe = ovf;

    AST_SAMPLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({samp_a, samp_b, samp_c})); // R8
endmodule

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic       div_wr;
    logic [7:0] div_wdata;
    logic       mode_sync, mode_fast, rx_raw;
    logic       baud_tick, ovs_strobe, rx_level;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    baud_gen dut (
        .clk(clk), .rst(rst), .div_wr(div_wr), .div_wdata(div_wdata),
        .mode_sync(mode_sync), .mode_fast(mode_fast), .rx_raw(rx_raw),
        .baud_tick(baud_tick), .ovs_strobe(ovs_strobe), .rx_level(rx_level)
    );

    // {sync, fast, X, ratio}
    localparam logic [16:0] VEC [0:11] = '{
        {1'b0, 1'b0, 8'd0,   7'd64}, {1'b0, 1'b0, 8'd1,   7'd64}, {1'b0, 1'b0, 8'd255, 7'd64},
        {1'b0, 1'b1, 8'd0,   7'd16}, {1'b0, 1'b1, 8'd1,   7'd16}, {1'b0, 1'b1, 8'd255, 7'd16},
        {1'b1, 1'b0, 8'd0,   7'd4},  {1'b1, 1'b0, 8'd1,   7'd4},  {1'b1, 1'b0, 8'd255, 7'd4},
        {1'b1, 1'b1, 8'd0,   7'd4},  {1'b1, 1'b1, 8'd1,   7'd4},  {1'b1, 1'b1, 8'd255, 7'd4}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_div(input logic [7:0] x);
        @(negedge clk);
        div_wr = 1'b1;
        div_wdata = x;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        while (!baud_tick) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic skip(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; div_wr = 1'b0; div_wdata = '0;
        mode_sync = 1'b0; mode_fast = 1'b0; rx_raw = 1'b1;
        skip(5);
        rst = 1'b0;
        chk("R1 tick low after reset", int'(baud_tick), 0);
        chk("R1 rx_level after reset", int'(rx_level), 1);
        wait_tick(n);
        chk("R1 first tick with divisor 0", n, 63);

        // table walk
        for (int r = 0; r < 12; r++) begin
            logic s, f;
            int x, p;
            string tag;
            s = VEC[r][16]; f = VEC[r][15]; x = int'(VEC[r][14:7]); p = int'(VEC[r][6:0]);
            tag = s ? "R5" : (f ? "R4" : "R3");
            @(negedge clk);
            mode_sync = s; mode_fast = f;
            wr_div(8'(x));
            wait_tick(n);
            chk({"R7 latency ", tag}, n, p * (x + 1) - 1);
            @(negedge clk);
            n = 1;
            while (!baud_tick) begin @(negedge clk); n++; end
            chk({tag, " tick spacing"}, n, p * (x + 1));
            while (!ovs_strobe) @(negedge clk);
            @(negedge clk);
            n = 1;
            while (!ovs_strobe) begin @(negedge clk); n++; end
            chk("R2 overflow spacing", n, x + 1);
        end

        // R6: tick one cycle wide (sync, X=0, fast ratio)
        @(negedge clk);
        mode_sync = 1'b1; mode_fast = 1'b0;
        wr_div(8'd0);
        wait_tick(n);
        chk("R6 tick with strobe", int'(ovs_strobe), 1);
        @(negedge clk);
        chk("R6 tick single cycle", int'(baud_tick), 0);

        // R7: mid-period write restarts
        @(negedge clk);
        mode_sync = 1'b0; mode_fast = 1'b0;
        wr_div(8'd20);
        skip(300);
        wr_div(8'd3);
        wait_tick(n);
        chk("R7 mid-period restart latency", n, 255);

        // R8/R9: async fast, X=9 -> samples at edges 70, 80, 90 after write
        @(negedge clk);
        mode_sync = 1'b0; mode_fast = 1'b1;
        wr_div(8'd9);
        for (int k = 1; k <= 92; k++) begin
            if (k == 74) rx_raw = 1'b0;
            if (k == 82) rx_raw = 1'b1;
            @(negedge clk);
        end
        chk("R9 single low sample rejected", int'(rx_level), 1);

        wr_div(8'd9);
        rx_raw = 1'b0;
        for (int k = 1; k <= 89; k++) @(negedge clk);
        chk("R8 level held before third sample", int'(rx_level), 1);
        @(negedge clk);
        chk("R8 level after third sample", int'(rx_level), 0);

        wr_div(8'd9);
        for (int k = 1; k <= 92; k++) begin
            if (k == 74) rx_raw = 1'b1;
            if (k == 82) rx_raw = 1'b0;
            @(negedge clk);
        end
        chk("R9 single high sample rejected", int'(rx_level), 0);

        wr_div(8'd9);
        for (int k = 1; k <= 92; k++) begin
            if (k == 74) rx_raw = 1'b1;
            @(negedge clk);
        end
        chk("R9 two high samples win", int'(rx_level), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule